// File: doc/BRIEF.md
# Coupled-Neuron Step Sequencer

This controller runs a time-stepped simulation of a population of coupled neurons on one shared, pipelined arithmetic datapath. It does not compute anything itself. On every tick it decides what the datapath, the per-neuron state memory, the external input stream and the connection-weight stream must do. It then raises the matching strobes.

A run starts with a `start_i` pulse. The pulse captures the operating mode and the number of steps to simulate. The controller first loads one initial state per neuron from the input stream. It then walks through the neurons step by step. In coupled mode, each neuron first spends a fixed accumulation loop of ceil(N/U) ticks, where U is the unroll factor. During each loop tick one batch of U weights is requested, and the loop always runs in full whatever the weight values are. After the loop the neuron is issued to the dendrite stage. Its result comes out of the pipeline a fixed number of ticks later and is written back into the state memory. Before each new coupled step, the pipeline is drained so that every neuron sees only the states of the previous step. In uncoupled mode, the loop and the drain between steps are both skipped, so one neuron is issued every tick.

Top module: `step_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o`, `in_rd_o`, `wgt_req_o`, `st_we_o`, `out_valid_o` and `dend_go_o` are low and `steps_done_o` is 0.
- R2: A `start_i` pulse in the idle state begins a load phase of exactly N ticks. Each load tick has `init_o`, `in_rd_o` and `st_we_o` high, and `st_waddr_o` runs 0, 1, …, N-1. No neuron is issued before the load phase ends.
- R3: In coupled mode, every issue of a neuron is preceded by exactly L = ceil(N/U) consecutive loop ticks. On those ticks `couple_o` and `wgt_req_o` are high and `loop_o` counts 0 to L-1. This count does not depend on connectivity.
- R4: `dend_go_o` is low on every loop tick. Each `dend_go_o` tick produces exactly one `out_valid_o` tick PIPE_DEPTH ticks later. On that later tick `st_we_o` is high and `st_waddr_o` equals the issued neuron index.
- R5: Each step issues neurons in the order 0 to N-1. Each issue tick consumes one input sample (`in_rd_o`) and reads that neuron's state (`st_re_o` high, `st_raddr_o` equal to the index).
- R6: In coupled mode, the first issue of a step occurs only after every output of the previous step has been written. A coupled step therefore lasts N·(L+1)+PIPE_DEPTH ticks.
- R7: In uncoupled mode, no loop ticks and no weight requests occur. Neurons are issued on consecutive ticks across step boundaries, and a single drain of PIPE_DEPTH ticks follows only the last step.
- R8: `steps_done_o` increments by one at the issue of the last neuron of each step. After the last output of the final step, `done_o` pulses for one tick with `steps_done_o` equal to the programmed total. The block then returns to idle and raises no further request.
- R9: A programmed total of zero steps gives the load phase followed directly by the `done_o` pulse, with no issue and no weight request.
- R10: `start_i`, `coupled_i` and `steps_total_i` are ignored while `busy_o` is high. The mode and the total are captured only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (idle only) |
| coupled_i | input | 1 | 1 = coupled mode, 0 = uncoupled; captured at start |
| steps_total_i | input | STEP_W | Number of steps to simulate; captured at start |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-tick pulse at end of run |
| init_o | output | 1 | Load-phase tick |
| couple_o | output | 1 | Coupling-loop tick |
| loop_o | output | LOOP_W | Coupling-loop iteration |
| wgt_req_o | output | 1 | Request one batch of U weights |
| dend_go_o | output | 1 | Issue current neuron to dendrite stage |
| in_rd_o | output | 1 | Consume one external input sample |
| st_re_o | output | 1 | State memory read strobe |
| st_raddr_o | output | IDX_W | State memory read index |
| st_we_o | output | 1 | State memory write strobe |
| st_waddr_o | output | IDX_W | State memory write index |
| out_valid_o | output | 1 | Datapath output valid |
| neuron_o | output | IDX_W | Current neuron index |
| steps_done_o | output | STEP_W | Completed steps |

## Verification
The bench builds the block with N=6, U=4 and PIPE_DEPTH=3. Because 6 is not a multiple of 4, the loop length is the rounded-up value 2, so the ceiling case is exercised. Because PIPE_DEPTH is smaller than N, results from one uncoupled step are still in flight while the next step is already being issued, which makes the back-to-back overlap visible at the ports. Because PIPE_DEPTH is greater than 1, the coupled drain spans several ticks, so its exact length shows up in the busy-tick total.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_LOOP,
    ST_ISSUE,
    ST_DRAIN,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/step_seq_ctrl.sv
module step_seq_ctrl import step_seq_pkg::*; #(
  parameter int N_NEURONS  = 16,
  parameter int UNROLL     = 4,
  parameter int PIPE_DEPTH = 4,
  parameter int STEP_W     = 16,
  localparam int IDX_W      = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1,
  localparam int LOOP_TICKS = (N_NEURONS + UNROLL - 1) / UNROLL,
  localparam int LOOP_W     = (LOOP_TICKS > 1) ? $clog2(LOOP_TICKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              coupled_i,
  input  logic [STEP_W-1:0] total_i,
  output seq_state_e        state_o,
  output logic [IDX_W-1:0]  neuron_o,
  output logic [LOOP_W-1:0] loop_o,
  output logic [STEP_W-1:0] steps_o,
  output logic [STEP_W-1:0] total_o,
  output logic              mode_o
);
  localparam int DRN_W = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1;
  localparam logic [IDX_W-1:0]  LAST_NRN  = IDX_W'(N_NEURONS - 1);
  localparam logic [LOOP_W-1:0] LAST_LOOP = LOOP_W'(LOOP_TICKS - 1);
  localparam logic [DRN_W-1:0]  LAST_DRN  = DRN_W'(PIPE_DEPTH - 1);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  nrn_q, nrn_d;
  logic [LOOP_W-1:0] loop_q, loop_d;
  logic [STEP_W-1:0] step_q, step_d, tot_q, tot_d;
  logic [DRN_W-1:0]  drn_q, drn_d;
  logic              mode_q, mode_d;
  logic [STEP_W-1:0] step_inc;

  assign step_inc = step_q + STEP_W'(1);

  always_comb begin
    state_d = state_q;
    nrn_d   = nrn_q;
    loop_d  = loop_q;
    step_d  = step_q;
    drn_d   = drn_q;
    mode_d  = mode_q;
    tot_d   = tot_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_INIT;
        nrn_d   = '0;
        loop_d  = '0;
        drn_d   = '0;
        step_d  = '0;
        mode_d  = coupled_i;
        tot_d   = total_i;
      end
      ST_INIT: begin
        if (nrn_q == LAST_NRN) begin
          nrn_d = '0;
          if (tot_q == '0) state_d = ST_DONE;
          else             state_d = mode_q ? ST_LOOP : ST_ISSUE;
        end else begin
          nrn_d = nrn_q + IDX_W'(1);
        end
      end
      ST_LOOP: begin
        if (loop_q == LAST_LOOP) begin
          loop_d  = '0;
          state_d = ST_ISSUE;
        end else begin
          loop_d = loop_q + LOOP_W'(1);
        end
      end
      ST_ISSUE: begin
        if (nrn_q != LAST_NRN) begin
          nrn_d   = nrn_q + IDX_W'(1);
          state_d = mode_q ? ST_LOOP : ST_ISSUE;
        end else begin
          nrn_d  = '0;
          step_d = step_inc;
          // uncoupled steps stream; drain only once at the end
          if (mode_q || step_inc == tot_q) begin
            state_d = ST_DRAIN;
            drn_d   = '0;
          end else begin
            state_d = ST_ISSUE;
          end
        end
      end
      ST_DRAIN: begin
        if (drn_q == LAST_DRN) begin
          drn_d   = '0;
          state_d = (step_q == tot_q) ? ST_DONE : ST_LOOP;
        end else begin
          drn_d = drn_q + DRN_W'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nrn_q   <= '0;
      loop_q  <= '0;
      step_q  <= '0;
      drn_q   <= '0;
      mode_q  <= 1'b0;
      tot_q   <= '0;
    end else begin
      state_q <= state_d;
      nrn_q   <= nrn_d;
      loop_q  <= loop_d;
      step_q  <= step_d;
      drn_q   <= drn_d;
      mode_q  <= mode_d;
      tot_q   <= tot_d;
    end
  end

  assign state_o  = state_q;
  assign neuron_o = nrn_q;
  assign loop_o   = loop_q;
  assign steps_o  = step_q;
  assign total_o  = tot_q;
  assign mode_o   = mode_q;

  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_INIT && !$stable(step_q)) |-> step_q == $past(step_q) + STEP_W'(1)); // R8
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_INIT && $past(state_q) != ST_IDLE) |-> $stable(mode_q) && $stable(tot_q)); // R10
endmodule

// File: rtl/step_seq_pipe.sv
module step_seq_pipe #(
  parameter int DEPTH = 4,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o
);
  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    adr_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic          vin;
    logic [AW-1:0] ain;
    if (g == 0) begin : g_head
      assign vin = go_i;
      assign ain = addr_i;
    end else begin : g_body
      assign vin = vld_q[g-1];
      assign ain = adr_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        adr_q[g] <= '0;
      end else begin
        vld_q[g] <= vin;
        adr_q[g] <= ain;
      end
    end
  end

  assign valid_o = vld_q[DEPTH-1];
  assign addr_o  = adr_q[DEPTH-1];
  assign busy_o  = |vld_q;
endmodule

// File: rtl/step_seq.sv
module step_seq import step_seq_pkg::*; #(
  parameter int N_NEURONS  = 16,
  parameter int UNROLL     = 4,
  parameter int PIPE_DEPTH = 4,
  parameter int STEP_W     = 16,
  localparam int IDX_W      = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1,
  localparam int LOOP_TICKS = (N_NEURONS + UNROLL - 1) / UNROLL,
  localparam int LOOP_W     = (LOOP_TICKS > 1) ? $clog2(LOOP_TICKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              coupled_i,
  input  logic [STEP_W-1:0] steps_total_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              init_o,
  output logic              couple_o,
  output logic [LOOP_W-1:0] loop_o,
  output logic              wgt_req_o,
  output logic              dend_go_o,
  output logic              in_rd_o,
  output logic              st_re_o,
  output logic [IDX_W-1:0]  st_raddr_o,
  output logic              st_we_o,
  output logic [IDX_W-1:0]  st_waddr_o,
  output logic              out_valid_o,
  output logic [IDX_W-1:0]  neuron_o,
  output logic [STEP_W-1:0] steps_done_o
);
  localparam logic [LOOP_W-1:0] LAST_LOOP = LOOP_W'(LOOP_TICKS - 1);

  seq_state_e        state;
  logic [IDX_W-1:0]  nrn;
  logic [STEP_W-1:0] total;
  logic              mode;
  logic              pipe_busy;
  logic [IDX_W-1:0]  pipe_addr;

  step_seq_ctrl #(
    .N_NEURONS (N_NEURONS),
    .UNROLL    (UNROLL),
    .PIPE_DEPTH(PIPE_DEPTH),
    .STEP_W    (STEP_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .coupled_i(coupled_i),
    .total_i  (steps_total_i),
    .state_o  (state),
    .neuron_o (nrn),
    .loop_o   (loop_o),
    .steps_o  (steps_done_o),
    .total_o  (total),
    .mode_o   (mode)
  );

  assign init_o    = (state == ST_INIT);
  assign couple_o  = (state == ST_LOOP);
  assign dend_go_o = (state == ST_ISSUE);
  assign done_o    = (state == ST_DONE);
  assign busy_o    = (state != ST_IDLE);
  assign wgt_req_o = couple_o;
  assign in_rd_o   = init_o | dend_go_o;
  assign st_re_o   = dend_go_o;
  assign st_raddr_o = nrn;
  assign neuron_o  = nrn;

  step_seq_pipe #(
    .DEPTH(PIPE_DEPTH),
    .AW   (IDX_W)
  ) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (dend_go_o),
    .addr_i (nrn),
    .valid_o(out_valid_o),
    .addr_o (pipe_addr),
    .busy_o (pipe_busy)
  );

  // load writes and pipeline writes never overlap: pipe is empty during load
  assign st_we_o    = init_o | out_valid_o;
  assign st_waddr_o = init_o ? nrn : pipe_addr;

  AST_LOOP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dend_go_o && mode) |-> ($past(couple_o) && $past(loop_o) == LAST_LOOP)); // R3
  AST_DRAIN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dend_go_o && mode && nrn == '0) |-> !pipe_busy); // R6
  AST_LOAD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |-> !out_valid_o); // R2
  AST_DONE_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (steps_done_o == total && !pipe_busy)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(in_rd_o || wgt_req_o || st_we_o || out_valid_o)); // R8
  AST_UNC_NO_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dend_go_o && !mode) |=> !couple_o); // R7
endmodule

// File: tb/step_seq_bench.sv
`timescale 1ns/1ps
module step_seq_bench;
  localparam int N  = 6;
  localparam int U  = 4;
  localparam int D  = 3;
  localparam int SW = 8;
  localparam int L  = (N + U - 1) / U;
  localparam int IW = $clog2(N);
  localparam int LW = (L > 1) ? $clog2(L) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic coupled = 1'b0;
  logic [SW-1:0] total = '0;
  logic busy_o, done_o, init_o, couple_o, wgt_req_o, dend_go_o, in_rd_o;
  logic st_re_o, st_we_o, out_valid_o;
  logic [LW-1:0] loop_o;
  logic [IW-1:0] st_raddr_o, st_waddr_o, neuron_o;
  logic [SW-1:0] steps_done_o;

  always #10 clk = ~clk;

  step_seq #(.N_NEURONS(N), .UNROLL(U), .PIPE_DEPTH(D), .STEP_W(SW)) u_step_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .coupled_i(coupled),
    .steps_total_i(total), .busy_o(busy_o), .done_o(done_o), .init_o(init_o),
    .couple_o(couple_o), .loop_o(loop_o), .wgt_req_o(wgt_req_o),
    .dend_go_o(dend_go_o), .in_rd_o(in_rd_o), .st_re_o(st_re_o),
    .st_raddr_o(st_raddr_o), .st_we_o(st_we_o), .st_waddr_o(st_waddr_o),
    .out_valid_o(out_valid_o), .neuron_o(neuron_o), .steps_done_o(steps_done_o)
  );

  int checks = 0;
  int errors = 0;
  int m_busy = 0, m_in = 0, m_wgt = 0, m_out = 0, m_we = 0, m_done = 0, m_go = 0;
  int m_init_err = 0, m_loop_err = 0, m_order_err = 0, m_drain_err = 0, m_overlap = 0;
  int init_idx = 0, go_idx = 0, out_idx = 0, lp = 0;
  bit cur_mode = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_o) m_busy++;
      if (in_rd_o) m_in++;
      if (wgt_req_o) m_wgt++;
      if (st_we_o) m_we++;
      if (done_o) m_done++;
      if (init_o) begin
        if (int'(st_waddr_o) != init_idx || !st_we_o) m_init_err++;
        init_idx = (init_idx + 1) % N;
      end
      if (couple_o) begin
        if (int'(loop_o) != lp || !wgt_req_o || dend_go_o) m_loop_err++;
        lp++;
      end
      if (dend_go_o) begin
        if (lp != (cur_mode ? L : 0)) m_loop_err++;
        lp = 0;
        if (int'(st_raddr_o) != go_idx || !st_re_o || !in_rd_o) m_order_err++;
        if (go_idx == 0 && m_go != m_out) begin
          if (cur_mode) m_drain_err++;
          else m_overlap++;
        end
        go_idx = (go_idx + 1) % N;
        m_go++;
      end
      if (out_valid_o) begin
        if (int'(st_waddr_o) != out_idx || !st_we_o) m_order_err++;
        out_idx = (out_idx + 1) % N;
        m_out++;
      end
    end
  end

  initial begin
    #(20ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // run one simulation; poke = pulse start mid-run with other settings
  task automatic run(input string tag, input bit c, input int s, input bit poke);
    int b_busy = m_busy, b_in = m_in, b_wgt = m_wgt, b_out = m_out, b_we = m_we;
    int b_done = m_done, b_ie = m_init_err, b_le = m_loop_err, b_oe = m_order_err;
    int b_de = m_drain_err, b_ov = m_overlap;
    int n = 0;
    int exp_busy, exp_in, exp_wgt;
    cur_mode = c;
    @(negedge clk);
    start = 1'b1; coupled = c; total = SW'(s);
    @(negedge clk);
    start = 1'b0; coupled = 1'b0; total = '0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
      if (poke && n == 10) begin start = 1'b1; coupled = !c; total = 8'd1; end
      else start = 1'b0;
    end
    start = 1'b0;
    chk({tag, " R8 steps at done"}, int'(steps_done_o), s);
    @(negedge clk);
    chk({tag, " R8 idle after done"}, int'(busy_o), 0);
    exp_in   = N + s * N;
    exp_wgt  = c ? s * N * L : 0;
    exp_busy = (s == 0) ? N + 1 : (c ? N + s * (N * (L + 1) + D) + 1 : N + s * N + D + 1);
    chk({tag, " R6 R7 R10 busy ticks"}, m_busy - b_busy, exp_busy);
    chk({tag, " R5 input samples"}, m_in - b_in, exp_in);
    chk({tag, " R3 weight batches"}, m_wgt - b_wgt, exp_wgt);
    chk({tag, " R4 outputs"}, m_out - b_out, s * N);
    chk({tag, " R2 R4 state writes"}, m_we - b_we, N + s * N);
    chk({tag, " R8 done pulses"}, m_done - b_done, 1);
    chk({tag, " R2 load order"}, m_init_err - b_ie, 0);
    chk({tag, " R3 loop ticks"}, m_loop_err - b_le, 0);
    chk({tag, " R4 R5 index order"}, m_order_err - b_oe, 0);
    chk({tag, " R6 drain"}, m_drain_err - b_de, 0);
    if (!c && s > 1) chk({tag, " R7 back to back steps"}, int'((m_overlap - b_ov) > 0), 1);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 strobes in reset", int'(in_rd_o | wgt_req_o | st_we_o | out_valid_o | dend_go_o | done_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 steps after reset", int'(steps_done_o), 0);
    chk("R1 strobes after reset", int'(in_rd_o | wgt_req_o | st_we_o | out_valid_o | dend_go_o | done_o), 0);
  endtask

  initial begin
    t_reset();
    run("coupled3", 1'b1, 3, 1'b0);   // R3 R6
    run("uncoupled4", 1'b0, 4, 1'b0); // R7
    run("zero", 1'b1, 0, 1'b0);       // R9
    run("zero_unc", 1'b0, 0, 1'b0);   // R9
    run("coupled1_poke", 1'b1, 1, 1'b1);   // R10
    run("uncoupled2_poke", 1'b0, 2, 1'b1); // R10
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule